// File: doc/BRIEF.md
# Floppy Disk DMA Channel

This block is a single-channel DMA engine. It takes a byte stream from a floppy disk controller and writes it into system memory, one byte per accepted beat. Software programs the channel through a small byte-wide register file. That file holds:

- a base address;
- a programmable transfer pointer;
- a 16-bit transfer length;
- a control/status byte.

A reset command places the pointer at a fixed distance above the base. A run command then loads a working address and a working counter from the programmed pointer and length. The channel streams until the working counter is exhausted. It then raises a status flag, which can be routed to an interrupt line.

Only the device-to-memory direction moves data. The direction bit can select memory-to-device, and it reads back as written, but in that state the input is never accepted.

Top module: `floppy_dma_chan`

## Requirements
- R1: The byte register map is as follows, with every multi-byte field big-endian (lowest offset holds the most significant byte).
  - Offsets 0-3 hold the base address and are read/write.
  - Offsets 4-7 hold the transfer pointer and are read/write.
  - Offsets 8-9 write the programmed length and read back the remaining working count.
  - Offset 10 is control/status.
  - Any other offset reads 0.
- R2: A write to offset 10 copies bit 1 (run), bit 3 (interrupt enable) and bit 6 (direction) from the written byte. The status read is {flag, dir, 0, 0, ie, 0, run, 0}, so bit 0 always reads 0.
- R3: A control write with bit 7 set clears the completion flag.
- R4: A control write with bit 0 set does the following:
  - clears the flag;
  - loads the pointer register with base + 0x15000;
  - loads the working address with the same value;
  - zeroes the working count;
  - takes run, ie and dir from the written byte as in R2.
- R5: A control write with bit 1 set loads the working address from the pointer and the working count from the programmed length. When bit 0 is set in the same write, the load uses the pointer value that the reset produced.
- R6: in_ready_o is high only while run=1, dir=0 (device-to-memory) and the working count is nonzero.
- R7: Each accepted byte (in_valid_i and in_ready_o high at a clock edge) produces mem_we_o in the next cycle, with mem_addr_o set to the working address and mem_data_o set to the byte. The same edge advances the working address by one and reduces the working count by one.
- R8: Accepting the byte that takes the working count to zero sets the flag (status bit 7) from the next cycle on. irq_o equals flag AND ie.
- R9: After rst_ni is asserted, all registers read 0, in_ready_o is low and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rdata_o | output | 8 | Register read byte (combinational on reg_addr_i) |
| in_valid_i | input | 1 | Input byte valid from disk controller |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Channel accepts input byte |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory write address |
| mem_data_o | output | 8 | Memory write byte |
| irq_o | output | 1 | Completion interrupt |

## Verification
A corrupted working address appears at mem_addr_o on the very next accepted byte. A corrupted working count is visible in two ways: the count readback at offsets 8-9, and in_ready_o falling early or late, so the last memory write and the flag move by one or more cycles. A reset or run command that loads the wrong source shows up on the first write after the run command. Because a reference model is compared on every clock, each such error is caught in the cycle it first reaches a port rather than at the end of the transfer.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int CTL_RST  = 0;
  localparam int CTL_RUN  = 1;
  localparam int CTL_IE   = 3;
  localparam int CTL_DIR  = 6;
  localparam int CTL_FLAG = 7;

  function automatic logic [7:0] pack_status(logic flag, logic dir, logic ie, logic run);
    logic [7:0] s;
    s = '0;
    s[CTL_FLAG] = flag;
    s[CTL_DIR]  = dir;
    s[CTL_IE]   = ie;
    s[CTL_RUN]  = run;
    return s;
  endfunction
endpackage

// File: rtl/fdma_regfile.sv
module fdma_regfile #(
  parameter int          ADDR_W  = 32,
  parameter int          CNT_W   = 16,
  parameter int          REG_AW  = 4,
  parameter logic [31:0] RST_OFS = 32'h0001_5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rst_cmd_i,
  input  logic [CNT_W-1:0]  wk_cnt_i,
  input  logic [7:0]        status_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        rdata_o
);
  localparam int AB       = ADDR_W / 8;
  localparam int CB       = CNT_W / 8;
  localparam int BASE_OFS = 0;
  localparam int PTR_OFS  = AB;
  localparam int CNT_OFS  = 2 * AB;
  localparam int CTL_OFS  = 2 * AB + CB;

  logic [ADDR_W-1:0] base_q, ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < AB; i++) begin
        if (we_i && addr_i == REG_AW'(BASE_OFS + i)) base_q[(AB-1-i)*8 +: 8] <= wdata_i;
        if (we_i && addr_i == REG_AW'(PTR_OFS + i))  ptr_q[(AB-1-i)*8 +: 8]  <= wdata_i;
      end
      for (int i = 0; i < CB; i++)
        if (we_i && addr_i == REG_AW'(CNT_OFS + i)) cnt_q[(CB-1-i)*8 +: 8] <= wdata_i;
      if (rst_cmd_i) ptr_q <= base_q + ADDR_W'(RST_OFS);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < AB; i++) begin
      if (addr_i == REG_AW'(BASE_OFS + i)) rdata_o = base_q[(AB-1-i)*8 +: 8];
      if (addr_i == REG_AW'(PTR_OFS + i))  rdata_o = ptr_q[(AB-1-i)*8 +: 8];
    end
    for (int i = 0; i < CB; i++)
      if (addr_i == REG_AW'(CNT_OFS + i)) rdata_o = wk_cnt_i[(CB-1-i)*8 +: 8];
    if (addr_i == REG_AW'(CTL_OFS)) rdata_o = status_i;
  end

  assign base_o = base_q;
  assign ptr_o  = ptr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
  import fdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  output logic       run_o,
  output logic       ie_o,
  output logic       dir_o,
  output logic       flag_o,
  output logic       rst_cmd_o,
  output logic       run_cmd_o,
  output logic [7:0] status_o
);
  logic run_q, ie_q, dir_q, flag_q;

  assign rst_cmd_o = ctl_we_i && wdata_i[CTL_RST];
  assign run_cmd_o = ctl_we_i && wdata_i[CTL_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      dir_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        run_q <= wdata_i[CTL_RUN];
        ie_q  <= wdata_i[CTL_IE];
        dir_q <= wdata_i[CTL_DIR];
      end
      // completion wins over a same-cycle clear so no event is lost
      if (done_i) flag_q <= 1'b1;
      else if (ctl_we_i && (wdata_i[CTL_FLAG] || wdata_i[CTL_RST])) flag_q <= 1'b0;
    end
  end

  assign run_o    = run_q;
  assign ie_o     = ie_q;
  assign dir_o    = dir_q;
  assign flag_o   = flag_q;
  assign status_o = pack_status(flag_q, dir_q, ie_q, run_q);
endmodule

// File: rtl/fdma_xfer.sv
module fdma_xfer #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_cmd_i,
  input  logic              run_cmd_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              run_i,
  input  logic              dir_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [CNT_W-1:0]  wk_cnt_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] wk_addr_q;
  logic [CNT_W-1:0]  wk_cnt_q;
  logic              accept;

  assign in_ready_o = run_i && !dir_i && (wk_cnt_q != '0);
  assign accept     = in_valid_i && in_ready_o;
  assign done_o     = accept && (wk_cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wk_addr_q <= '0;
      wk_cnt_q  <= '0;
    end else if (run_cmd_i) begin
      wk_addr_q <= load_addr_i;
      wk_cnt_q  <= load_cnt_i;
    end else if (rst_cmd_i) begin
      wk_addr_q <= load_addr_i;
      wk_cnt_q  <= '0;
    end else if (accept) begin
      wk_addr_q <= wk_addr_q + ADDR_W'(1);
      wk_cnt_q  <= wk_cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= accept;
      if (accept) begin
        mem_addr_o <= wk_addr_q;
        mem_data_o <= in_data_i;
      end
    end
  end

  assign wk_cnt_o = wk_cnt_q;
endmodule

// File: rtl/floppy_dma_chan.sv
module floppy_dma_chan #(
  parameter int          ADDR_W  = 32,
  parameter int          CNT_W   = 16,
  parameter int          REG_AW  = 4,
  parameter logic [31:0] RST_OFS = 32'h0001_5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              irq_o
);
  localparam int CTL_OFS = 2 * (ADDR_W / 8) + CNT_W / 8;

  logic [ADDR_W-1:0] base_w, ptr_w, load_addr_w;
  logic [CNT_W-1:0]  cnt_w, wk_cnt_w;
  logic [7:0]        status_w;
  logic              ctl_we_w, rst_cmd_w, run_cmd_w, done_w;
  logic              run_w, ie_w, dir_w, flag_w;

  assign ctl_we_w    = reg_we_i && reg_addr_i == REG_AW'(CTL_OFS);
  assign load_addr_w = rst_cmd_w ? base_w + ADDR_W'(RST_OFS) : ptr_w;
  assign irq_o       = flag_w && ie_w;

  fdma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW), .RST_OFS(RST_OFS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rst_cmd_i(rst_cmd_w), .wk_cnt_i(wk_cnt_w),
    .status_i(status_w), .base_o(base_w), .ptr_o(ptr_w), .cnt_o(cnt_w),
    .rdata_o(reg_rdata_o)
  );

  fdma_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_we_i(ctl_we_w), .wdata_i(reg_wdata_i),
    .done_i(done_w), .run_o(run_w), .ie_o(ie_w), .dir_o(dir_w), .flag_o(flag_w),
    .rst_cmd_o(rst_cmd_w), .run_cmd_o(run_cmd_w), .status_o(status_w)
  );

  fdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_cmd_i(rst_cmd_w), .run_cmd_i(run_cmd_w),
    .load_addr_i(load_addr_w), .load_cnt_i(cnt_w), .run_i(run_w), .dir_i(dir_w),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .wk_cnt_o(wk_cnt_w), .done_o(done_w)
  );
endmodule

// File: rtl/fdma_chk.sv
module fdma_chk #(
  parameter int          ADDR_W  = 32,
  parameter int          CNT_W   = 16,
  parameter int          REG_AW  = 4,
  parameter logic [31:0] RST_OFS = 32'h0001_5000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              mem_we_o,
  input logic              irq_o,
  input logic              run_i,
  input logic              dir_i,
  input logic              ie_i,
  input logic              flag_i,
  input logic [CNT_W-1:0]  wk_cnt_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic [ADDR_W-1:0] base_i
);
  localparam int CTL_OFS = 2 * (ADDR_W / 8) + CNT_W / 8;

  logic ctl_wr, acc;
  assign ctl_wr = reg_we_i && reg_addr_i == REG_AW'(CTL_OFS);
  assign acc    = in_valid_i && in_ready_o;

  assert_ready_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (run_i && !dir_i && wk_cnt_i != '0));

  assert_mem_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> mem_we_o);

  assert_mem_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(acc));

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !ctl_wr) |=> wk_cnt_i == $past(wk_cnt_i) - CNT_W'(1));

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_i && flag_i));

  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wk_cnt_i == CNT_W'(1)) |=> flag_i);

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && reg_wdata_i[7] && !(acc && wk_cnt_i == CNT_W'(1))) |=> !flag_i);

  assert_rst_ptr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && reg_wdata_i[0]) |=> (ptr_i == $past(base_i) + ADDR_W'(RST_OFS)));
endmodule

bind floppy_dma_chan fdma_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW), .RST_OFS(RST_OFS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .mem_we_o(mem_we_o), .irq_o(irq_o), .run_i(run_w), .dir_i(dir_w), .ie_i(ie_w),
  .flag_i(flag_w), .wk_cnt_i(wk_cnt_w), .ptr_i(ptr_w), .base_i(base_w)
);

// File: tb/floppy_dma_chan_tb.sv
module floppy_dma_chan_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o, mem_we_o, irq_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  floppy_dma_chan u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] m_base = 0, m_ptr = 0, m_wa = 0, m_maddr = 0;
  int          m_cprog = 0, m_wc = 0;
  bit          m_run = 0, m_ie = 0, m_dir = 0, m_flag = 0, m_we = 0;
  logic [7:0]  m_mdata = 0;
  logic [7:0]  mem_log[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_base = 0; m_ptr = 0; m_wa = 0; m_maddr = 0; m_cprog = 0; m_wc = 0;
      m_run = 0; m_ie = 0; m_dir = 0; m_flag = 0; m_we = 0; m_mdata = 0;
    end else begin
      bit acc, done, ctl, rc;
      acc  = in_valid_i && m_run && !m_dir && m_wc != 0;
      done = acc && m_wc == 1;
      ctl  = reg_we_i && reg_addr_i == 4'd10;
      rc   = ctl && reg_wdata_i[0];
      m_we = acc;
      if (acc) begin
        m_maddr = m_wa; m_mdata = in_data_i; mem_log.push_back(in_data_i);
        m_wa = m_wa + 1; m_wc = m_wc - 1;
      end
      if (reg_we_i && reg_addr_i < 4) m_base[(3 - reg_addr_i) * 8 +: 8] = reg_wdata_i;
      if (reg_we_i && reg_addr_i >= 4 && reg_addr_i < 8) m_ptr[(7 - reg_addr_i) * 8 +: 8] = reg_wdata_i;
      if (reg_we_i && reg_addr_i == 8) m_cprog = (m_cprog & 'h00ff) | (int'(reg_wdata_i) << 8);
      if (reg_we_i && reg_addr_i == 9) m_cprog = (m_cprog & 'hff00) | int'(reg_wdata_i);
      if (rc) begin m_ptr = m_base + 32'h15000; m_wa = m_ptr; m_wc = 0; end
      if (ctl && reg_wdata_i[1]) begin m_wa = m_ptr; m_wc = m_cprog; end
      if (ctl) begin m_run = reg_wdata_i[1]; m_ie = reg_wdata_i[3]; m_dir = reg_wdata_i[6]; end
      if (done) m_flag = 1;
      else if (ctl && (reg_wdata_i[7] || reg_wdata_i[0])) m_flag = 0;
    end
  end

  function automatic logic [7:0] m_rd(logic [3:0] a);
    if (a < 4) return m_base[(3 - a) * 8 +: 8];
    if (a < 8) return m_ptr[(7 - a) * 8 +: 8];
    if (a == 8) return 8'(m_wc >> 8);
    if (a == 9) return 8'(m_wc);
    if (a == 10) return {m_flag, m_dir, 2'b00, m_ie, 1'b0, m_run, 1'b0};
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    chk("R6 in_ready_o", 32'(in_ready_o), 32'(m_run && !m_dir && m_wc != 0));
    chk("R8 irq_o", 32'(irq_o), 32'(m_flag && m_ie));
    chk("R7 mem_we_o", 32'(mem_we_o), 32'(m_we));
    if (m_we) begin
      chk("R7 mem_addr_o", mem_addr_o, m_maddr);
      chk("R7 mem_data_o", 32'(mem_data_o), 32'(m_mdata));
    end
    chk("R1 reg_rdata_o", 32'(reg_rdata_o), 32'(m_rd(reg_addr_i)));
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    reg_addr_i = a;
    cyc();
    chk(tag, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic stream(int n, logic [7:0] seed, bit gaps);
    for (int i = 0; i < n; i++) begin
      in_valid_i = 1; in_data_i = seed + 8'(i);
      cyc();
      if (gaps && i[0]) begin in_valid_i = 0; cyc(); end
    end
    in_valid_i = 0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R9 reset state
    rd(4'd10, 8'h00, "R9 status after reset");
    rd(4'd3, 8'h00, "R9 base after reset");
    chk("R9 ready after reset", 32'(in_ready_o), 0);
    // R1 base, big-endian lanes
    wr(4'd0, 8'h00); wr(4'd1, 8'h12); wr(4'd2, 8'h34); wr(4'd3, 8'h00);
    rd(4'd1, 8'h12, "R1 base byte1 msb side");
    rd(4'd2, 8'h34, "R1 base byte2");
    wr(4'd8, 8'h00); wr(4'd9, 8'h05);
    rd(4'd9, 8'h00, "R1 count reads working count");
    rd(4'd15, 8'h00, "R1 unmapped offset");
    // R4 reset command with ie
    wr(4'd10, 8'h09);
    rd(4'd10, 8'h08, "R4 status keeps ie, bit0 clear");
    rd(4'd4, 8'h00, "R4 ptr byte0");
    rd(4'd5, 8'h13, "R4 ptr byte1");
    rd(4'd6, 8'h84, "R4 ptr byte2");
    // R5 run reloads
    wr(4'd10, 8'h0A);
    rd(4'd10, 8'h0A, "R2 status run+ie");
    rd(4'd9, 8'h05, "R5 working count loaded");
    chk("R6 ready with run", 32'(in_ready_o), 1);
    stream(5, 8'hA0, 1'b1);
    cyc();
    chk("R7 last address", mem_addr_o, 32'h0013_8404);
    rd(4'd9, 8'h00, "R7 final count zero");
    rd(4'd10, 8'h8A, "R8 flag set");
    chk("R8 irq raised", 32'(irq_o), 1);
    chk("R6 ready low at zero", 32'(in_ready_o), 0);
    in_valid_i = 1; cyc(); cyc(); in_valid_i = 0;
    chk("R6 no write after done", 32'(mem_we_o), 0);
    chk("R7 five bytes written", mem_log.size(), 5);
    // R3 write-one-to-clear
    wr(4'd10, 8'h8A);
    rd(4'd10, 8'h0A, "R3 flag cleared");
    chk("R3 irq dropped", 32'(irq_o), 0);
    // R6 direction blocks input
    wr(4'd4, 8'h00); wr(4'd5, 8'h20); wr(4'd6, 8'h00); wr(4'd7, 8'h00);
    rd(4'd5, 8'h20, "R1 ptr byte write");
    wr(4'd9, 8'h03);
    wr(4'd10, 8'h42);
    rd(4'd10, 8'h42, "R2 status dir");
    in_valid_i = 1; cyc(); cyc(); in_valid_i = 0;
    chk("R6 ready low with dir", 32'(in_ready_o), 0);
    chk("R6 no memory write with dir", 32'(mem_we_o), 0);
    // R5 reset+run in one write uses reset pointer; ie off
    wr(4'd10, 8'h03);
    rd(4'd10, 8'h02, "R5 status after rst+run");
    stream(3, 8'h50, 1'b0);
    cyc();
    chk("R5 rst+run address", mem_addr_o, 32'h0013_8402);
    rd(4'd10, 8'h82, "R8 flag without ie");
    chk("R8 irq masked", 32'(irq_o), 0);
    wr(4'd10, 8'h08);
    chk("R8 irq follows ie", 32'(irq_o), 1);
    wr(4'd10, 8'h80);
    rd(4'd10, 8'h00, "R3 clear with run off");
    repeat (4) cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule